// File: doc/BRIEF.md
# I2C Bus Condition and Arbitration Monitor

This block observes the two wires of an I2C bus after synchronisation and reports the bus conditions that a master/slave controller needs: START and STOP events, whether the bus is occupied, and whether this node has lost arbitration. The controller feeds in what it is driving on SDA, which bit phase it is in, whether it is acting as master, and any pending START, repeated-START or STOP request. The monitor compares these against what the wires actually show.

Five separate causes of arbitration loss are reported. They are: a data mismatch while transmitting, a mismatch in the ACK slot of a master receive, a START request on a busy bus, a repeated-START request while in slave mode, and a STOP that this master did not ask for. Each cause has its own pulse bit. All causes share one pulse that the controller can use to fall back to slave mode and raise an interrupt. A sticky flag holds the loss until software clears it.

Top module: `i2c_bus_monitor`

## Requirements
- R1: A falling SDA with SCL high on both consecutive synchronised samples produces a one-cycle `start_det` pulse, visible in the third clock cycle after the raw SDA change.
- R2: A rising SDA with SCL high on both consecutive synchronised samples produces a one-cycle `stop_det` pulse, with the same three-cycle latency as R1.
- R3: `bus_busy` goes high in the same cycle as `start_det` and goes low in the same cycle as `stop_det`.
- R4: On an SCL rising sample, when `is_master`, `tx_phase` and `sda_drive` are all 1 and the synchronised SDA is 0, `arb_cause[0]` pulses.
- R5: On an SCL rising sample, when `is_master`, `rx_ack_phase` and `sda_drive` are all 1 and the synchronised SDA is 0, `arb_cause[1]` pulses.
- R6: `start_req` while `bus_busy` is 1 pulses `arb_cause[2]` one cycle later. With the bus idle the request has no effect.
- R7: `rstart_req` while `is_master` is 0 pulses `arb_cause[3]` one cycle later. As master the request has no effect.
- R8: A STOP detected while `is_master` is 1 and no `stop_req` has been seen since the last STOP pulses `arb_cause[4]` together with `stop_det`. A pending request suppresses this cause and is consumed by the STOP. In slave mode a STOP never raises this cause.
- R9: `arb_lost` stays 1 until a cycle with `arb_clr` high clears it on the next edge. A new loss in the same cycle as `arb_clr` keeps it at 1.
- R10: `arb_event` is a one-cycle pulse in exactly the cycles where any `arb_cause` bit is 1, and `arb_lost` is 1 in those cycles.
- R11: After reset, `start_det`, `stop_det`, `bus_busy`, `arb_lost`, `arb_event` and `arb_cause` are all 0.
- R12: SDA changes while SCL is low produce neither `start_det` nor `stop_det`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw SCL wire level |
| sda_in | input | 1 | Raw SDA wire level |
| sda_drive | input | 1 | Value this node intends on SDA (1 = released/high) |
| tx_phase | input | 1 | Address or data bit is being transmitted |
| rx_ack_phase | input | 1 | ACK slot of a master data-receive byte |
| is_master | input | 1 | Controller is in master mode |
| start_req | input | 1 | START request pulse |
| rstart_req | input | 1 | Repeated-START request pulse |
| stop_req | input | 1 | STOP request pulse |
| arb_clr | input | 1 | Software clear of the arbitration-lost flag |
| start_det | output | 1 | START detected pulse |
| stop_det | output | 1 | STOP detected pulse |
| bus_busy | output | 1 | Bus occupied between START and STOP |
| arb_lost | output | 1 | Sticky arbitration-lost flag |
| arb_event | output | 1 | One-cycle arbitration-loss pulse |
| arb_cause | output | 5 | Per-cause arbitration-loss pulses |

## Verification
Results that depend on the wires are due three edges after a raw line change: two synchroniser flops, then the output register. Results that follow the request inputs are due one edge after the request. The bench drives every stimulus on a falling clock edge. It then waits exactly that many rising edges and samples at the next falling edge. Where the cycle just before the due cycle matters, the bench checks that cycle too, and it checks the cycle after to confirm that each pulse lasts one cycle. The two data-compare causes are swept over all 32 combinations of mode, phase, driven value and line level, and the expected bits are computed arithmetically.

// File: rtl/i2c_mon_pkg.sv
package i2c_mon_pkg;
    localparam int NUM_CAUSE = 5;
    localparam int CAUSE_TX_MISMATCH  = 0;
    localparam int CAUSE_ACK_MISMATCH = 1;
    localparam int CAUSE_BUSY_START   = 2;
    localparam int CAUSE_SLAVE_RSTART = 3;
    localparam int CAUSE_STRAY_STOP   = 4;

    typedef logic [NUM_CAUSE-1:0] cause_t;

    typedef struct packed {
        logic prev_scl;
        logic prev_sda;
        logic start;
        logic stop;
        logic busy;
    } cond_state_t;

    typedef struct packed {
        logic   stop_pend;
        logic   event_p;
        logic   lost;
        cause_t cause;
    } arb_state_t;
endpackage

// File: rtl/i2c_mon_sync.sv
module i2c_mon_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q, chain_d;

    always_comb begin
        chain_d[0] = raw_i;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/i2c_mon_cond.sv
module i2c_mon_cond
    import i2c_mon_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic start_o,
    output logic stop_o,
    output logic busy_o,
    output logic stop_now_o,
    output logic scl_rise_o
);
    cond_state_t st_q, st_d;
    logic scl_high;

    always_comb begin
        st_d          = st_q;
        scl_high      = st_q.prev_scl & scl_s;
        st_d.prev_scl = scl_s;
        st_d.prev_sda = sda_s;
        st_d.start    = scl_high & st_q.prev_sda & ~sda_s;
        st_d.stop     = scl_high & ~st_q.prev_sda & sda_s;
        if (st_d.start)     st_d.busy = 1'b1;
        else if (st_d.stop) st_d.busy = 1'b0;
        stop_now_o    = st_d.stop;
        scl_rise_o    = ~st_q.prev_scl & scl_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{prev_scl: 1'b1, prev_sda: 1'b1, default: 1'b0};
        else        st_q <= st_d;
    end

    assign start_o = st_q.start;
    assign stop_o  = st_q.stop;
    assign busy_o  = st_q.busy;

    assert_start_stop_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_o && stop_o));
    assert_busy_on_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> busy_o);
    assert_idle_on_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |-> !busy_o);
    assert_start_one_cycle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);
endmodule

// File: rtl/i2c_mon_arb.sv
module i2c_mon_arb
    import i2c_mon_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   scl_rise,
    input  logic   sda_s,
    input  logic   stop_now,
    input  logic   busy,
    input  logic   sda_drive,
    input  logic   tx_phase,
    input  logic   rx_ack_phase,
    input  logic   is_master,
    input  logic   start_req,
    input  logic   rstart_req,
    input  logic   stop_req,
    input  logic   arb_clr,
    output logic   lost_o,
    output logic   event_o,
    output cause_t cause_o
);
    arb_state_t st_q, st_d;
    logic mismatch;

    always_comb begin
        st_d     = st_q;
        mismatch = scl_rise & is_master & sda_drive & ~sda_s;
        st_d.cause[CAUSE_TX_MISMATCH]  = mismatch & tx_phase;
        st_d.cause[CAUSE_ACK_MISMATCH] = mismatch & rx_ack_phase;
        st_d.cause[CAUSE_BUSY_START]   = start_req & busy;
        st_d.cause[CAUSE_SLAVE_RSTART] = rstart_req & ~is_master;
        st_d.cause[CAUSE_STRAY_STOP]   = stop_now & is_master & ~st_q.stop_pend;
        if (stop_now) st_d.stop_pend = 1'b0;
        if (stop_req) st_d.stop_pend = 1'b1;
        st_d.event_p = |st_d.cause;
        if (arb_clr)      st_d.lost = 1'b0;
        if (st_d.event_p) st_d.lost = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lost_o  = st_q.lost;
    assign event_o = st_q.event_p;
    assign cause_o = st_q.cause;

    assert_sticky_lost_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (lost_o && !arb_clr) |=> lost_o);
    assert_event_sets_lost_R10: assert property (@(posedge clk) disable iff (!rst_n)
        event_o |-> lost_o);
    assert_event_has_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        event_o |-> ($countones(cause_o) > 0));
    assert_slave_no_mismatch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(is_master) |-> (cause_o[CAUSE_TX_MISMATCH] == 1'b0));
endmodule

// File: rtl/i2c_bus_monitor.sv
module i2c_bus_monitor
    import i2c_mon_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scl_in,
    input  logic                 sda_in,
    input  logic                 sda_drive,
    input  logic                 tx_phase,
    input  logic                 rx_ack_phase,
    input  logic                 is_master,
    input  logic                 start_req,
    input  logic                 rstart_req,
    input  logic                 stop_req,
    input  logic                 arb_clr,
    output logic                 start_det,
    output logic                 stop_det,
    output logic                 bus_busy,
    output logic                 arb_lost,
    output logic                 arb_event,
    output logic [NUM_CAUSE-1:0] arb_cause
);
    localparam int LINES = 2;

    logic [LINES-1:0] lines_s;
    logic stop_now, scl_rise;

    i2c_mon_sync #(.STAGES(SYNC_STAGES), .WIDTH(LINES)) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  ({scl_in, sda_in}),
        .sync_o (lines_s)
    );

    i2c_mon_cond cond_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_s      (lines_s[1]),
        .sda_s      (lines_s[0]),
        .start_o    (start_det),
        .stop_o     (stop_det),
        .busy_o     (bus_busy),
        .stop_now_o (stop_now),
        .scl_rise_o (scl_rise)
    );

    i2c_mon_arb arb_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_rise     (scl_rise),
        .sda_s        (lines_s[0]),
        .stop_now     (stop_now),
        .busy         (bus_busy),
        .sda_drive    (sda_drive),
        .tx_phase     (tx_phase),
        .rx_ack_phase (rx_ack_phase),
        .is_master    (is_master),
        .start_req    (start_req),
        .rstart_req   (rstart_req),
        .stop_req     (stop_req),
        .arb_clr      (arb_clr),
        .lost_o       (arb_lost),
        .event_o      (arb_event),
        .cause_o      (arb_cause)
    );

    assert_stop_cause_with_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        arb_cause[CAUSE_STRAY_STOP] |-> stop_det);
    assert_no_start_scl_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(scl_in, 3) && !$past(scl_in, 2)) |-> !start_det);
endmodule

// File: tb/i2c_bus_monitor_tb_top.sv
module i2c_bus_monitor_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_in = 1'b1, sda_in = 1'b1, sda_drive = 1'b1;
    logic tx_phase = 1'b0, rx_ack_phase = 1'b0, is_master = 1'b0;
    logic start_req = 1'b0, rstart_req = 1'b0, stop_req = 1'b0, arb_clr = 1'b0;
    logic start_det, stop_det, bus_busy, arb_lost, arb_event;
    logic [4:0] arb_cause;
    int total = 0;
    int fails = 0;

    always #10 clk = ~clk;

    i2c_bus_monitor dut_i (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .sda_drive(sda_drive), .tx_phase(tx_phase), .rx_ack_phase(rx_ack_phase),
        .is_master(is_master), .start_req(start_req), .rstart_req(rstart_req),
        .stop_req(stop_req), .arb_clr(arb_clr), .start_det(start_det),
        .stop_det(stop_det), .bus_busy(bus_busy), .arb_lost(arb_lost),
        .arb_event(arb_event), .arb_cause(arb_cause)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic lines(input logic c, input logic d);
        scl_in = c; sda_in = d; step(4);
    endtask

    task automatic do_start;
        lines(1'b1, 1'b1); sda_in = 1'b0; step(4);
    endtask

    task automatic clear_lost;
        arb_clr = 1'b1; step(1); arb_clr = 1'b0;
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        check("R11 reset outputs", {2'b0, start_det, stop_det, bus_busy, arb_lost, arb_event, 1'b0}, 8'h00);
        check("R11 reset cause", {3'b0, arb_cause}, 8'h00);

        lines(1'b0, 1'b1);
        sda_in = 1'b0; step(3);
        check("R12 sda fall scl low", {7'b0, start_det | stop_det}, 8'h00);
        step(1);
        sda_in = 1'b1; step(3);
        check("R12 sda rise scl low", {7'b0, start_det | stop_det}, 8'h00);
        step(1);

        lines(1'b1, 1'b1);
        sda_in = 1'b0; step(2);
        check("R1 start not early", {7'b0, start_det}, 8'h00);
        step(1);
        check("R1 start pulse", {7'b0, start_det}, 8'h01);
        check("R3 busy set", {7'b0, bus_busy}, 8'h01);
        step(1);
        check("R1 start one cycle", {7'b0, start_det}, 8'h00);

        lines(1'b0, 1'b0); lines(1'b1, 1'b0);
        sda_in = 1'b1; step(3);
        check("R2 stop pulse", {7'b0, stop_det}, 8'h01);
        check("R3 busy cleared", {7'b0, bus_busy}, 8'h00);
        check("R8 slave stop no cause", {7'b0, arb_event}, 8'h00);
        step(1);
        check("R2 stop one cycle", {7'b0, stop_det}, 8'h00);

        start_req = 1'b1; step(1); start_req = 1'b0;
        check("R6 idle start ok", {7'b0, arb_event}, 8'h00);
        do_start;
        start_req = 1'b1; step(1); start_req = 1'b0;
        check("R6 busy start cause", {3'b0, arb_cause}, 8'h04);
        check("R10 event with cause", {6'b0, arb_event, arb_lost}, 8'h03);
        step(1);
        check("R10 event one cycle", {7'b0, arb_event}, 8'h00);
        check("R9 lost sticky", {7'b0, arb_lost}, 8'h01);
        clear_lost;
        check("R9 lost cleared", {7'b0, arb_lost}, 8'h00);

        is_master = 1'b0;
        rstart_req = 1'b1; arb_clr = 1'b1; step(1); rstart_req = 1'b0; arb_clr = 1'b0;
        check("R7 slave rstart cause", {3'b0, arb_cause}, 8'h08);
        check("R9 set beats clear", {7'b0, arb_lost}, 8'h01);
        clear_lost;
        is_master = 1'b1;
        rstart_req = 1'b1; step(1); rstart_req = 1'b0;
        check("R7 master rstart ok", {6'b0, arb_event, arb_lost}, 8'h00);

        lines(1'b0, 1'b0); lines(1'b1, 1'b0);
        sda_in = 1'b1; step(3);
        check("R8 stray stop cause", {3'b0, arb_cause}, 8'h10);
        check("R8 stray stop det", {7'b0, stop_det}, 8'h01);
        step(1); clear_lost;

        do_start;
        stop_req = 1'b1; step(1); stop_req = 1'b0;
        lines(1'b0, 1'b0); lines(1'b1, 1'b0);
        sda_in = 1'b1; step(3);
        check("R8 requested stop", {6'b0, stop_det, arb_event}, 8'h02);
        step(1);

        do_start;
        lines(1'b0, 1'b0); lines(1'b1, 1'b0);
        sda_in = 1'b1; step(3);
        check("R8 request consumed", {3'b0, arb_cause}, 8'h10);
        step(1); clear_lost;

        for (int k = 0; k < 32; k++) begin
            logic tx, ack, m, drv, lvl, e0, e1;
            {tx, ack, m, drv, lvl} = 5'(k);
            e0 = tx & m & drv & ~lvl;
            e1 = ack & m & drv & ~lvl;
            scl_in = 1'b0; step(4);
            sda_in = lvl; tx_phase = tx; rx_ack_phase = ack;
            is_master = m; sda_drive = drv; step(4);
            scl_in = 1'b1; step(3);
            check("R4 tx mismatch sweep", {7'b0, arb_cause[0]}, {7'b0, e0});
            check("R5 ack mismatch sweep", {7'b0, arb_cause[1]}, {7'b0, e1});
            check("R10 sweep event", {7'b0, arb_event}, {7'b0, e0 | e1});
            tx_phase = 1'b0; rx_ack_phase = 1'b0;
            clear_lost;
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule